// File: doc/BRIEF.md
# Edge-Selectable Multi-Pin Wakeup Unit

The unit watches a bank of general-purpose input pins and records a chosen transition on any of them as a wakeup event. Each pin first passes through a synchronizer. Its edge is then found by comparing the newest synchronized sample with the one before it. Software picks, per pin, whether the rising or the falling transition counts. A detected transition sets a sticky pending flag for that pin. The flag stays set until software clears it by writing a one to that bit.

A second register decides, per pin, whether a pending flag may wake the core. Its bits are active low: a zero arms the pin and a one masks it. The wakeup request goes to the sleep sequencer. It is raised only while the core reports that it is asleep and at least one armed pin has its pending flag set. Pending flags are collected whether or not the core is asleep. Software can therefore poll them at any time through the pending output.

Top module: `wkup_unit`

## Requirements
- R1: After reset the pending flags read 8'h00, every pin is masked (enable register 8'hFF, active low), and every pin selects the falling edge (edge register 8'hFF).
- R2: A pending flag raises the wakeup request only when its enable bit is 0. A pending pin whose enable bit is 1 never raises the request.
- R3: Edge-select bit 1 means a high-to-low transition counts for that pin, and 0 means a low-to-high transition counts. The opposite transition leaves the pending flag unchanged.
- R4: A counted transition on a pin sets its pending flag on the third rising clock edge after the pin changes (two synchronizer stages plus the history flop). This happens regardless of the enable bit and of the sleep input.
- R5: Writing the pending register (wr_sel = 2) clears each flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged. A flag never clears in any other way except by reset.
- R6: When a counted transition and a clear of the same bit fall in the same cycle, the flag ends up set. Other bits in the same clear write still clear.
- R7: wake_req equals sleep_active AND the OR over all pins of (pending AND NOT enable bit). It is 0 whenever sleep_active is 0.
- R8: Any combination of pins can record transitions in the same cycle, and each one sets only its own pending bit.
- R9: Write select encoding: 0 writes the enable register, 1 writes the edge register, 2 clears pending flags, and 3 has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 8 | Asynchronous pin levels |
| sleep_active | input | 1 | High while the core is in power-down |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_sel | input | 2 | Register selector (0 enable, 1 edge, 2 pending clear, 3 none) |
| wr_data | input | 8 | Write data |
| wake_req | output | 1 | Wakeup request to the sleep sequencer |
| pend_out | output | 8 | Pending flags |

## Verification
The checker assumes that pins change no faster than the synchronizer can follow. It also assumes that write strobes are single-cycle pulses with a stable selector and data, because it links a falling pending flag to the clear write of the cycle before. The bench drives pins and writes only on falling clock edges. It holds each pin level for at least three cycles, and it leaves wr_sel at 3 whenever wr_en is low. The one deliberate overlap of a transition and a clear is timed so that the clear lands exactly on the cycle in which the detected edge is presented.

// File: rtl/wkup_pkg.sv
// Shared definitions for the wakeup unit.
// Assumes: a two-bit write selector driven by the core's register access.
package wkup_pkg;

    typedef enum logic [1:0] {
        SEL_ENABLE   = 2'd0,
        SEL_EDGE     = 2'd1,
        SEL_PEND_CLR = 2'd2,
        SEL_NONE     = 2'd3
    } wr_sel_e;

endpackage

// File: rtl/wkup_sync.sv
// Multi-stage synchronizer for a bank of asynchronous pins.
// Assumes: STAGES >= 1; pins are held long enough to be sampled.
module wkup_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    // First stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= async_in;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage re-times the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/wkup_edge_det.sv
// Per-pin edge detector with a selectable transition direction.
// Assumes: sync_in is already in the clock domain; edge_sel bit 1 = falling.
module wkup_edge_det #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sync_in,
    input  logic [WIDTH-1:0] edge_sel,
    output logic [WIDTH-1:0] evt
);

    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] rise;
    logic [WIDTH-1:0] fall;

    // Keep the prior synchronized sample for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_in;
    end

    // Raw transitions in both directions.
    always_comb begin
        rise = sync_in & ~prev_q;
        fall = ~sync_in & prev_q;
    end

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pick
            assign evt[i] = edge_sel[i] ? fall[i] : rise[i];
        end
    endgenerate

endmodule

// File: rtl/wkup_cfg_regs.sv
// Enable (active low) and edge-select registers, both resetting to all ones.
// Assumes: wr_en is a single-cycle strobe with wr_sel and wr_data valid.
module wkup_cfg_regs
    import wkup_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] enable_n,
    output logic [WIDTH-1:0] edge_sel
);

    localparam logic [WIDTH-1:0] RESET_ONES = '1;

    // Enable register: a 0 arms the matching pin.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   enable_n <= RESET_ONES;
        else if (wr_en && wr_sel == 2'(SEL_ENABLE))   enable_n <= wr_data;
    end

    // Edge register: a 1 selects the falling transition.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   edge_sel <= RESET_ONES;
        else if (wr_en && wr_sel == 2'(SEL_EDGE))     edge_sel <= wr_data;
    end

endmodule

// File: rtl/wkup_pending.sv
// Sticky pending flags with write-one-to-clear and set-over-clear priority.
// Assumes: evt is a one-cycle indication per detected transition.
module wkup_pending
    import wkup_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] pend
);

    logic [WIDTH-1:0] clr_mask;

    // Decode which bits the current write clears.
    always_comb begin
        clr_mask = '0;
        if (wr_en && wr_sel == 2'(SEL_PEND_CLR)) clr_mask = wr_data;
    end

    // Clear first, then set, so a new event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_mask) | evt;
    end

endmodule

// File: rtl/wkup_unit.sv
// Top of the wakeup unit: sync, edge detect, config, pending, request.
// Assumes: sleep_active comes from the sleep sequencer in the same clock domain.
module wkup_unit #(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                sleep_active,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [NUM_PINS-1:0] wr_data,
    output logic                wake_req,
    output logic [NUM_PINS-1:0] pend_out
);

    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] pin_evt;
    logic [NUM_PINS-1:0] enable_n;
    logic [NUM_PINS-1:0] edge_sel;
    logic [NUM_PINS-1:0] armed;

    wkup_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    wkup_edge_det #(.WIDTH(NUM_PINS)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (pin_sync),
        .edge_sel (edge_sel),
        .evt      (pin_evt)
    );

    wkup_cfg_regs #(.WIDTH(NUM_PINS)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .enable_n (enable_n),
        .edge_sel (edge_sel)
    );

    wkup_pending #(.WIDTH(NUM_PINS)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (pin_evt),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .pend    (pend_out)
    );

    // Pending flags of pins that are armed by an active-low enable bit.
    always_comb armed = pend_out & ~enable_n;

    // Request only while asleep.
    always_comb wake_req = sleep_active & (|armed);

endmodule

// File: rtl/wkup_unit_checker.sv
// Property checker for wkup_unit, attached by bind.
// Assumes: wr_en is a single-cycle strobe; reset is synchronous active low.
module wkup_unit_checker
    import wkup_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sleep_active,
    input logic                wr_en,
    input logic [1:0]          wr_sel,
    input logic [NUM_PINS-1:0] wr_data,
    input logic [NUM_PINS-1:0] pin_evt,
    input logic [NUM_PINS-1:0] pend_out,
    input logic                wake_req
);

    logic [NUM_PINS-1:0] clr_req;
    always_comb clr_req = (wr_en && wr_sel == 2'(SEL_PEND_CLR)) ? wr_data : '0;

    // R1: reset empties the pending flags
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> pend_out == '0);

    // R7: no request while awake
    assert_wake_needs_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> sleep_active);

    // R2: a request needs some pending flag
    assert_wake_needs_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> pend_out != '0);

    // R5: a flag only drops after a clear of that bit
    assert_clear_only_by_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pend_out) & ~pend_out & ~$past(clr_req)) == '0));

    // R4: a flag only rises after a detected transition
    assert_set_only_by_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~$past(pend_out) & pend_out & ~$past(pin_evt)) == '0));

    // R6: every detected transition is recorded, even against a clear
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_out & $past(pin_evt)) == $past(pin_evt)));

endmodule

bind wkup_unit wkup_unit_checker #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_active (sleep_active),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .pin_evt      (pin_evt),
    .pend_out     (pend_out),
    .wake_req     (wake_req)
);

// File: tb/wkup_unit_test.sv
// Directed bench for wkup_unit: one task per scenario.
module wkup_unit_test;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_in = 8'h00;
    logic       sleep_active = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd3;
    logic [7:0] wr_data = 8'h00;
    logic       wake_req;
    logic [7:0] pend_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wkup_unit uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_in       (pin_in),
        .sleep_active (sleep_active),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .wake_req     (wake_req),
        .pend_out     (pend_out)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [7:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3; wr_data = 8'h00;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic t_reset();
        check("R1 pending after reset", pend_out, 8'h00);
        sleep_active = 1'b1;
        pin_in[3] = 1'b1;             // rising: default selects falling
        cycles(3);
        check("R1 default falling ignores rise", pend_out, 8'h00);
        pin_in[3] = 1'b0;
        cycles(2);
        check("R4 not yet after two cycles", pend_out, 8'h00);
        cycles(1);
        check("R4 set on third cycle", pend_out, 8'h08);
        check("R1 default masked, no wake", {7'd0, wake_req}, 8'h00);
        sleep_active = 1'b0;
    endtask

    task automatic t_enable();
        reg_write(2'd0, 8'hF7);
        check("R7 awake gives no wake", {7'd0, wake_req}, 8'h00);
        sleep_active = 1'b1;
        #1;
        check("R2 armed pin wakes", {7'd0, wake_req}, 8'h01);
        reg_write(2'd0, 8'hFF);
        check("R2 masked pin no wake", {7'd0, wake_req}, 8'h00);
        check("R4 pending kept regardless of enable", pend_out, 8'h08);
        sleep_active = 1'b0;
    endtask

    task automatic t_clear();
        reg_write(2'd3, 8'hFF);
        check("R9 select 3 no effect", pend_out, 8'h08);
        reg_write(2'd2, 8'h00);
        check("R5 zero write keeps", pend_out, 8'h08);
        reg_write(2'd2, 8'hF7);
        check("R5 other bits keep", pend_out, 8'h08);
        reg_write(2'd2, 8'h08);
        check("R5 one clears", pend_out, 8'h00);
    endtask

    task automatic t_rising();
        reg_write(2'd1, 8'hFE);
        pin_in[0] = 1'b1;
        cycles(3);
        check("R3 rising selected", pend_out, 8'h01);
        reg_write(2'd2, 8'hFF);
        pin_in[0] = 1'b0;
        cycles(3);
        check("R3 falling ignored when rising selected", pend_out, 8'h00);
    endtask

    task automatic t_combo();
        reg_write(2'd1, 8'h00);
        reg_write(2'd0, 8'hF7);
        pin_in = 8'hA5;
        cycles(3);
        check("R8 many pins at once", pend_out, 8'hA5);
        sleep_active = 1'b1;
        #1;
        check("R2 only masked pins pending", {7'd0, wake_req}, 8'h00);
        reg_write(2'd0, 8'h5F);
        check("R7 armed subset wakes", {7'd0, wake_req}, 8'h01);
        sleep_active = 1'b0;
        #1;
        check("R7 wake drops when awake", {7'd0, wake_req}, 8'h00);
        reg_write(2'd2, 8'hFF);
        pin_in = 8'h00;
        cycles(3);
        check("R3 opposite edges ignored", pend_out, 8'h00);
    endtask

    task automatic t_priority();
        pin_in[0] = 1'b1;
        cycles(4);
        check("R4 pin0 pending", pend_out, 8'h01);
        pin_in[1] = 1'b1;             // rising edge on pin1
        cycles(2);                     // edge now presented to pending stage
        wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h03;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3; wr_data = 8'h00;
        check("R6 set wins over clear", pend_out, 8'h02);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_clear();
        t_rising();
        t_combo();
        t_priority();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule